// File: doc/BRIEF.md
# Region-Based Data Access Guard

This block sits beside a data port and decides, within the same cycle, whether a load or store may go ahead. It holds four protection windows and a fallback permission set. The fallback applies whenever no window claims the address. Each window has a base register and an attribute register. The attribute register carries an enable flag, read and write permissions, and a size code. The size code is a run of low-order ones. Every extra one doubles the window, starting from 4 KB.

The base is never checked for alignment. Any base bits that fall inside the window size are dropped, so the window always starts on its natural boundary. Size codes are also not checked. A code whose ones are not contiguous is used as a raw "don't care" mask over the page bits. The result is odd but repeatable.

Software programs the registers through a simple write port. It then sets a master enable. While that enable is clear, every access is allowed. The permission decision is combinational. A registered copy of the fault flag is also provided for timing-relaxed consumers.

Top module: `region_guard`

## Requirements
- R1: After a synchronous reset, all registers are zero: every window is disabled, the fallback grants nothing and the master enable is clear. In this state every access is allowed and `acc_fault` is 0.
- R2: While the master enable is clear, `acc_fault` and `hit_any` are 0 and `acc_allow` is 1, whatever the window contents.
- R3: A size code with k low-order ones (value 2^k−1) selects a window of 4096·2^k bytes. An address hits when its bits from 12 upward equal the effective base bits outside the mask.
- R4: Base bits inside the size mask are ignored, so the effective base is the programmed base rounded down to the window size. Example: code 0x3 with base 0x0000_1000 covers 0x0000_0000 to 0x0000_3FFF.
- R5: A window whose enable bit is 0 never hits.
- R6: When several windows hit, the lowest-numbered one supplies the permissions, and its number appears on `hit_index`.
- R7: When no window hits, the fallback read/write permissions decide.
- R8: `acc_fault` = master enable AND `acc_valid` AND (a write without write permission OR a read without read permission). `acc_allow` is its inverse, and `acc_fault` is 0 whenever `acc_valid` is 0.
- R9: `acc_fault_q` equals the value `acc_fault` had in the previous cycle, and is 0 after reset.
- R10: A size code that is not contiguous is applied unchecked as a raw mask. Example: code 0x2 with base 0x0000_1000 hits 0x1000–0x1FFF and 0x3000–0x3FFF, but not 0x0000 or 0x2000.
- R11: Write map on `cfg_addr`:
  - 0–3: base of window n, taken from data bits [31:12].
  - 4–7: attributes of window n. Bit 0 is enable, bit 1 is read, bit 2 is write, bits [27:8] are the size code.
  - 8: fallback permissions. Bit 1 is read, bit 2 is write.
  - 9: control. Bit 0 is the master enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | An access is presented |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 32 | Access byte address |
| acc_allow | output | 1 | Access permitted |
| acc_fault | output | 1 | Permission violation (combinational) |
| acc_fault_q | output | 1 | Fault flag delayed one cycle |
| hit_any | output | 1 | Some enabled window claims the address |
| hit_index | output | 2 | Winning window number |

## Verification
The bench probes the last byte inside each window and the first byte beyond it. A design that rounds the base wrongly, or that compares the masked page bits, moves a boundary by a page and miscompares there. Overlapping windows with conflicting permissions expose a reversed priority, because the store outcome flips. A disabled window placed over a fallback-only area catches any design that ignores the enable bit. The non-contiguous code 0x2 shows a design that normalises size codes instead of masking, because that design claims or drops the 0x2000 page. Randomised legal configurations in the low and high address ranges are checked against a divide-and-compare model of the windows.

// File: rtl/region_guard_pkg.sv
`timescale 1ns/1ps
package region_guard_pkg;
    localparam int ADDR_W   = 32;
    localparam int PAGE_LSB = 12;
    localparam int PAGE_W   = ADDR_W - PAGE_LSB;
    localparam int NREG     = 4;
    localparam int IDX_W    = $clog2(NREG);
    localparam int CFG_AW   = $clog2(2 * NREG + 2);
    localparam int SIZE_LSB = 8;
    localparam int EN_BIT   = 0;
    localparam int RD_BIT   = 1;
    localparam int WR_BIT   = 2;
    localparam int GLB_SEL  = 2 * NREG;
    localparam int CTL_SEL  = 2 * NREG + 1;

    typedef logic [PAGE_W-1:0] page_t;

    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
    } perm_t;

    typedef struct packed {
        page_t size_mask;
        perm_t perm;
        logic  en;
    } attr_t;

    function automatic attr_t decode_attr(input logic [ADDR_W-1:0] w);
        attr_t a;
        a.size_mask  = w[SIZE_LSB +: PAGE_W];
        a.perm.rd_ok = w[RD_BIT];
        a.perm.wr_ok = w[WR_BIT];
        a.en         = w[EN_BIT];
        return a;
    endfunction

    function automatic perm_t decode_perm(input logic [ADDR_W-1:0] w);
        perm_t p;
        p.rd_ok = w[RD_BIT];
        p.wr_ok = w[WR_BIT];
        return p;
    endfunction

    function automatic page_t snap_base(input page_t base, input page_t mask);
        return base & ~mask;
    endfunction

    function automatic logic denied(input perm_t p, input logic is_write);
        return is_write ? !p.wr_ok : !p.rd_ok;
    endfunction
endpackage

// File: rtl/rg_regfile.sv
`timescale 1ns/1ps
module rg_regfile
    import region_guard_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [CFG_AW-1:0]  waddr,
    input  logic [ADDR_W-1:0]  wdata,
    output page_t              base_pages [NREG],
    output attr_t              attrs      [NREG],
    output perm_t              gperm,
    output logic               master_en
);
    logic [NREG-1:0] en_vec;
    logic            wdata_unused;

    assign wdata_unused = ^{wdata[ADDR_W-1:SIZE_LSB+PAGE_W], wdata[SIZE_LSB-1:WR_BIT+1]};

    for (genvar i = 0; i < NREG; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst) begin
                base_pages[i] <= '0;
                attrs[i]      <= '0;
            end else if (we) begin
                if (waddr == CFG_AW'(i))
                    base_pages[i] <= wdata[ADDR_W-1:PAGE_LSB];
                if (waddr == CFG_AW'(NREG + i))
                    attrs[i] <= decode_attr(wdata);
            end
        end
        assign en_vec[i] = attrs[i].en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gperm     <= '0;
            master_en <= 1'b0;
        end else if (we) begin
            if (waddr == CFG_AW'(GLB_SEL))
                gperm <= decode_perm(wdata);
            if (waddr == CFG_AW'(CTL_SEL))
                master_en <= wdata[EN_BIT];
        end
    end

    AST_RST_CLEARS_ALL: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!master_en && en_vec == '0 && gperm == '0)); // R1
endmodule

// File: rtl/rg_window_match.sv
`timescale 1ns/1ps
module rg_window_match
    import region_guard_pkg::*;
(
    input  page_t page,
    input  page_t base_page,
    input  attr_t attr,
    output logic  hit
);
    page_t eff_base;
    page_t cmp_page;

    always_comb begin
        eff_base = snap_base(base_page, attr.size_mask);
        cmp_page = page & ~attr.size_mask;
        hit      = attr.en && (cmp_page == eff_base);
    end
endmodule

// File: rtl/rg_resolver.sv
`timescale 1ns/1ps
module rg_resolver
    import region_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NREG-1:0]  hits,
    input  attr_t            attrs [NREG],
    input  perm_t            gperm,
    input  logic             master_en,
    input  logic             valid,
    input  logic             is_write,
    output logic             fault,
    output logic             any_hit,
    output logic [IDX_W-1:0] win_idx
);
    logic             found;
    logic [IDX_W-1:0] pick;
    perm_t            eff;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                pick  = IDX_W'(i);
            end
        end
        eff     = found ? attrs[pick].perm : gperm;
        fault   = master_en && valid && denied(eff, is_write);
        any_hit = master_en && found;
        win_idx = master_en ? pick : '0;
    end

    AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !master_en |-> (!fault && !any_hit)); // R2
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> (hits[win_idx] && (hits & ((NREG'(1) << win_idx) - NREG'(1))) == '0)); // R6
    AST_MISS_USES_FALLBACK: assert property (@(posedge clk) disable iff (rst)
        (master_en && valid && hits == '0) |-> (fault == (is_write ? !gperm.wr_ok : !gperm.rd_ok))); // R7
endmodule

// File: rtl/region_guard.sv
`timescale 1ns/1ps
module region_guard
    import region_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              acc_allow,
    output logic              acc_fault,
    output logic              acc_fault_q,
    output logic              hit_any,
    output logic [IDX_W-1:0]  hit_index
);
    page_t           base_pages [NREG];
    attr_t           attrs      [NREG];
    perm_t           gperm;
    logic            master_en;
    logic [NREG-1:0] hits;
    logic            addr_unused;

    assign addr_unused = ^acc_addr[PAGE_LSB-1:0];

    rg_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (cfg_we),
        .waddr      (cfg_addr),
        .wdata      (cfg_wdata),
        .base_pages (base_pages),
        .attrs      (attrs),
        .gperm      (gperm),
        .master_en  (master_en)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_match
        rg_window_match u_match (
            .page      (acc_addr[ADDR_W-1:PAGE_LSB]),
            .base_page (base_pages[i]),
            .attr      (attrs[i]),
            .hit       (hits[i])
        );
    end

    rg_resolver u_resolve (
        .clk       (clk),
        .rst       (rst),
        .hits      (hits),
        .attrs     (attrs),
        .gperm     (gperm),
        .master_en (master_en),
        .valid     (acc_valid),
        .is_write  (acc_write),
        .fault     (acc_fault),
        .any_hit   (hit_any),
        .win_idx   (hit_index)
    );

    assign acc_allow = !acc_fault;

    always_ff @(posedge clk) begin
        if (rst) acc_fault_q <= 1'b0;
        else     acc_fault_q <= acc_fault;
    end

    AST_FAULT_DELAYED: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (acc_fault_q == $past(acc_fault))); // R9
endmodule

// File: tb/region_guard_tb_top.sv
`timescale 1ns/1ps
module region_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_allow, acc_fault, acc_fault_q, hit_any;
    logic [1:0]  hit_index;

    int n_vec = 0;
    int n_err = 0;

    logic [31:0] sb   [4];
    int          scode[4];
    bit          sen  [4];
    bit          srd  [4];
    bit          swr  [4];
    bit          grd, gwr, men;

    always #2.5 clk = ~clk;

    region_guard dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_allow(acc_allow), .acc_fault(acc_fault), .acc_fault_q(acc_fault_q),
        .hit_any(hit_any), .hit_index(hit_index)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h (addr %h we %0d)", req, act, exp, acc_addr, acc_write);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // R11: base at n, attributes at 4+n (en bit0, rd bit1, wr bit2, size [27:8])
    task automatic set_win(input int n, input logic [31:0] base, input int code,
                           input bit en, input bit rd, input bit wr);
        reg_wr(4'(n), base);
        reg_wr(4'(4 + n), (32'(code) << 8) | {29'd0, wr, rd, en});
        sb[n] = base; scode[n] = code; sen[n] = en; srd[n] = rd; swr[n] = wr;
    endtask

    task automatic set_fallback(input bit rd, input bit wr);
        reg_wr(4'd8, {29'd0, wr, rd, 1'b0});
        grd = rd; gwr = wr;
    endtask

    task automatic set_master(input bit e);
        reg_wr(4'd9, {31'd0, e});
        men = e;
    endtask

    // Arithmetic model for contiguous codes: window = 4096*(code+1), base rounded down
    task automatic predict(input logic [31:0] a, input bit w, input bit v,
                           output bit eh, output int ei, output bit ef);
        longint sz, lo;
        bit rd, wr;
        eh = 0; ei = 0; rd = grd; wr = gwr;
        if (men) begin
            for (int i = 3; i >= 0; i--) begin
                if (sen[i]) begin
                    sz = 64'd4096 * (longint'(scode[i]) + 1);
                    lo = (longint'(sb[i]) / sz) * sz;
                    if (longint'(a) >= lo && longint'(a) < lo + sz) begin
                        eh = 1; ei = i; rd = srd[i]; wr = swr[i];
                    end
                end
            end
        end
        ef = men && v && (w ? !wr : !rd);
    endtask

    task automatic apply_exp(input logic [31:0] a, input bit w, input bit v,
                             input bit eh, input int ei, input bit ef, input string tag);
        @(negedge clk);
        acc_addr = a; acc_write = w; acc_valid = v;
        #1;
        chk({tag, " fault/R8"}, {31'd0, acc_fault}, {31'd0, ef});
        chk({tag, " allow/R8"}, {31'd0, acc_allow}, {31'd0, !ef});
        chk({tag, " hit"}, {31'd0, hit_any}, {31'd0, eh});
        if (eh) chk({tag, " index/R6"}, {30'd0, hit_index}, 32'(ei));
        @(posedge clk); #1;
        chk("R9 delayed fault", {31'd0, acc_fault_q}, {31'd0, ef});
    endtask

    task automatic apply(input logic [31:0] a, input bit w, input bit v, input string tag);
        bit eh, ef;
        int ei;
        predict(a, w, v, eh, ei, ef);
        apply_exp(a, w, v, eh, ei, ef, tag);
    endtask

    task automatic wipe();
        for (int i = 0; i < 4; i++) set_win(i, 32'd0, 0, 0, 0, 0);
        set_fallback(0, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin sb[i] = 0; scode[i] = 0; sen[i] = 0; srd[i] = 0; swr[i] = 0; end
        grd = 0; gwr = 0; men = 0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state allows everything, no fault, no hit
        apply_exp(32'h0000_0000, 1'b0, 1'b1, 0, 0, 0, "R1");
        apply_exp(32'hFFFF_F000, 1'b1, 1'b1, 0, 0, 0, "R1");
        set_master(1);
        apply_exp(32'h0000_4000, 1'b0, 1'b1, 0, 0, 1, "R1 zero fallback");

        // R4 / R3: code 0x3 (16 KB) with base 0x1000 snaps to 0x0
        set_win(0, 32'h0000_1000, 3, 1, 1, 0);
        apply_exp(32'h0000_0000, 1'b0, 1'b1, 1, 0, 0, "R4 snapped start");
        apply_exp(32'h0000_3FFF, 1'b0, 1'b1, 1, 0, 0, "R4 last byte");
        apply_exp(32'h0000_3FFF, 1'b1, 1'b1, 1, 0, 1, "R8 write to read-only");
        apply_exp(32'h0000_4000, 1'b0, 1'b1, 0, 0, 1, "R3 beyond window");
        apply_exp(32'h0000_2000, 1'b1, 1'b0, 1, 0, 0, "R8 idle access");

        // R10: non-contiguous code 0x2 masks only bit 13
        set_win(0, 32'h0000_1000, 2, 1, 1, 1);
        apply_exp(32'h0000_1000, 1'b1, 1'b1, 1, 0, 0, "R10 hit low");
        apply_exp(32'h0000_3FFF, 1'b0, 1'b1, 1, 0, 0, "R10 hit alias");
        apply_exp(32'h0000_0000, 1'b0, 1'b1, 0, 0, 1, "R10 miss 0x0");
        apply_exp(32'h0000_2000, 1'b0, 1'b1, 0, 0, 1, "R10 miss 0x2000");
        apply_exp(32'h0000_5000, 1'b0, 1'b1, 0, 0, 1, "R10 miss 0x5000");

        // R6: overlapping windows with conflicting permissions
        wipe();
        set_win(0, 32'h0002_0000, 1, 1, 1, 0);
        set_win(1, 32'h0002_0000, 15, 1, 1, 1);
        set_win(3, 32'h0002_1000, 0, 1, 0, 0);
        apply(32'h0002_0000, 1'b1, 1'b1, "R6 low wins");
        apply(32'h0002_1FFF, 1'b1, 1'b1, "R6 low wins over 3");
        apply(32'h0002_2000, 1'b1, 1'b1, "R6 next window");
        apply(32'h0002_FFFF, 1'b0, 1'b1, "R3 64K last");
        apply(32'h0003_0000, 1'b0, 1'b1, "R7 past 64K");

        // R5 / R7: disabled window over fallback-only space
        set_fallback(1, 0);
        set_win(2, 32'h0004_0000, 3, 0, 1, 1);
        apply_exp(32'h0004_0000, 1'b1, 1'b1, 0, 0, 1, "R5 disabled write");
        apply_exp(32'h0004_0000, 1'b0, 1'b1, 0, 0, 0, "R7 fallback read");

        // R2: master off silences everything
        set_master(0);
        for (int k = 0; k < 8; k++) apply_exp(32'h0002_0000 + 32'(k) * 32'h3000, k[0], 1'b1, 0, 0, 0, "R2");
        set_master(1);

        // R3/R4/R6/R7 randomised legal configurations, low and high address ranges
        for (int c = 0; c < 10; c++) begin
            logic [31:0] hi;
            hi = c[0] ? 32'hFFF0_0000 : 32'h0000_0000;
            for (int n = 0; n < 4; n++) begin
                int k;
                k = int'($urandom % 6);
                set_win(n, hi + ($urandom % 32'h0006_0000), (1 << k) - 1,
                        ($urandom % 4) != 0, $urandom % 2, $urandom % 2);
            end
            set_fallback($urandom % 2, $urandom % 2);
            for (int n = 0; n < 4; n++) begin
                longint sz, lo;
                sz = 64'd4096 * (longint'(scode[n]) + 1);
                lo = (longint'(sb[n]) / sz) * sz;
                apply(32'(lo), 1'b0, 1'b1, "R4 rand start");
                apply(32'(lo + sz - 1), 1'b1, 1'b1, "R3 rand end");
                apply(32'(lo + sz), 1'b0, 1'b1, "R3 rand past");
                if (lo > 0) apply(32'(lo - 1), 1'b1, 1'b1, "R4 rand before");
            end
            for (int s = 0; s < 256; s++)
                apply(hi + 32'(s) * 32'h800, s[0] ^ s[3], 1'b1, "R6/R7 sweep");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule